// File: doc/BRIEF.md
# Phase-Continuous FSK Modulator

The block turns a serial bit stream into a digital frequency-shift-keyed waveform for a DAC. A 32-bit phase accumulator feeds a quarter-wave sine table, forming a direct digital synthesiser. The increment added to the phase on every sample is the carrier tuning word plus the deviation word while the current bit is a one (mark), or the carrier word minus the deviation word while it is a zero (space). Carrier and deviation are plain input words, so any carrier in the 5 to 21 MHz band and any deviation near 75 kHz can be chosen without changing the hardware. The sample clock is set at 60 MHz or more, which keeps it above twice the highest output frequency.

Bit pacing comes from a 32-bit fractional accumulator. A rate word is added to it on every sample, and each carry out becomes a one-cycle request to the upstream source for the next bit. With the rate word set to 2^32 times 39.4 kHz divided by the sample rate, the average symbol period is exact and no integer divider rounding builds up. The phase accumulator is never cleared at a symbol boundary, so a switch between mark and space leaves no phase step in the output.

A two-state controller follows the enable input. In the paused state the output sits at zero, requests stop, and the phase and pacing accumulators keep their values. In the running state the block advances and takes a bit when a request meets a valid bit. State `ST_PAUSE` goes to `ST_RUN` when enable is high. State `ST_RUN` goes to `ST_PAUSE` when enable is low. Each state stays where it is otherwise.

Top module: `fsk_modulator`

## Requirements
- R1: While rst_n is low, sample is 0 and bit_req is 0. The phase accumulator, the pacing accumulator and the held bit are all reset to 0.
- R2: On every clock edge with enable high, rate_word is added modulo 2^32 to the pacing accumulator. bit_req is high for exactly the cycle after an edge whose addition carried out, and low otherwise.
- R3: At an edge where enable, bit_req and data_valid are all high, the held bit takes data_bit. At every other edge the held bit keeps its value, so the previous bit is repeated when no new bit is offered.
- R4: On every enabled edge the 32-bit phase grows, modulo 2^32, by carrier_word + deviation_word if the held bit before that edge is 1, or by carrier_word - deviation_word if it is 0. The phase is never cleared except by reset.
- R5: At each enabled edge, sample is loaded with the table value for the phase as it stood before that edge. The output therefore lags the phase by one register.
- R6: The value for a phase is taken from its top 8 bits. Bits [31:30] are the quadrant q and bits [29:24] are an index i. If q is 1 or 3 the index is mirrored to 63-i. With x = 2i+1, the magnitude is floor(2047*4*x*(256-x) / (81920 - x*(256-x))). It is negated when q is 2 or 3.
- R7: At an edge with enable low, sample becomes 0, bit_req becomes 0, the held bit does not change, and both accumulators hold their values. When enable returns, the output continues from the held phase.
- R8: sample is a 12-bit two's-complement value. The second half-turn of the phase is the exact negative of the first, the second quadrant mirrors the first, and -2048 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high; pause with zero output when low |
| carrier_word | input | 32 | Carrier tuning word (2^32 * f / fs) |
| deviation_word | input | 32 | Deviation tuning word |
| rate_word | input | 32 | Bit-rate word for the pacing accumulator |
| data_bit | input | 1 | Next bit offered by the upstream source |
| data_valid | input | 1 | data_bit is valid this cycle |
| bit_req | output | 1 | One-cycle request for the next bit |
| sample | output | 12 | Signed waveform sample |

## Verification
A wrong increment or a spurious phase clear shows up as a wrong sample value on the very next enabled edge, because every sample is a direct readout of the phase. The per-cycle comparison therefore catches a phase fault one cycle after it happens. A pacing accumulator that drifts or loses a carry moves a bit_req pulse by at least one cycle, which is seen at once. A bit that is latched wrongly or not held is seen one cycle later as a change in the phase step. A table fault shows up only when the phase reaches the affected entry, so the sweep walks all 256 entries of the top phase bits.

// File: rtl/fskmod_pkg.sv
package fskmod_pkg;

    typedef enum logic [0:0] {
        ST_PAUSE = 1'b0,
        ST_RUN   = 1'b1
    } run_state_t;

    // Rational sine approximation over a quarter table of 2**aw entries,
    // sampled at half-step centres so the mirror is exact.
    function automatic int quarter_mag(input int idx, input int aw, input int amp);
        int qn;
        int half_turn;
        int x;
        int prod;
        qn        = 1 << aw;
        half_turn = 4 * qn;
        x         = 2 * idx + 1;
        prod      = x * (half_turn - x);
        return (amp * 4 * prod) / (20 * qn * qn - prod);
    endfunction

endpackage

// File: rtl/fsk_rate_gen.sv
module fsk_rate_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [ACC_W-1:0] rate_i,
    output logic             req_o
);

    logic [ACC_W-1:0] frac_q;
    logic [ACC_W:0]   sum_w;

    assign sum_w = {1'b0, frac_q} + {1'b0, rate_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
            req_o  <= 1'b0;
        end else if (step_i) begin
            frac_q <= sum_w[ACC_W-1:0];
            req_o  <= sum_w[ACC_W];
        end else begin
            req_o  <= 1'b0;
        end
    end

    // R7: a paused edge leaves no request behind
    a_r7_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> !req_o);

    // R7: pacing accumulator holds while paused
    a_r7_frac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(frac_q));

    // R2: a zero rate never produces a request
    a_r2_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == '0) |=> !req_o);

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               mark_i,
    input  logic [PHASE_W-1:0] carrier_i,
    input  logic [PHASE_W-1:0] dev_i,
    output logic [PHASE_W-1:0] phase_o
);

    logic [PHASE_W-1:0] incr_w;

    always_comb begin
        if (mark_i) incr_w = carrier_i + dev_i;
        else        incr_w = carrier_i - dev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase_o <= '0;
        else if (step_i) phase_o <= phase_o + incr_w;
    end

    // R7: phase is kept across a pause
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(phase_o));

    // R4: mark and space steps differ by twice the deviation
    a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mark_i && $stable(carrier_i) && $stable(dev_i) && $past(step_i) && !$past(mark_i))
        |=> (phase_o - $past(phase_o)) == ($past(phase_o) - $past(phase_o, 2)) + 2 * $past(dev_i));

endmodule

// File: rtl/fsk_sine_out.sv
module fsk_sine_out #(
    parameter int LUT_AW = 6,
    parameter int OUT_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic [LUT_AW+1:0]       phase_top_i,
    output logic signed [OUT_W-1:0] sample_o
);

    localparam int QN    = 1 << LUT_AW;
    localparam int MAG_W = OUT_W - 1;
    localparam int AMP   = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] mag_tab [QN];

    for (genvar g = 0; g < QN; g++) begin : g_tab
        assign mag_tab[g] = MAG_W'(fskmod_pkg::quarter_mag(g, LUT_AW, AMP));
    end

    logic [1:0]              quad_w;
    logic [LUT_AW-1:0]       idx_w;
    logic [MAG_W-1:0]        mag_w;
    logic signed [OUT_W-1:0] mag_s;
    logic signed [OUT_W-1:0] val_w;

    always_comb begin
        quad_w = phase_top_i[LUT_AW+1:LUT_AW];
        idx_w  = quad_w[0] ? ~phase_top_i[LUT_AW-1:0] : phase_top_i[LUT_AW-1:0];
        mag_w  = mag_tab[idx_w];
        mag_s  = signed'({1'b0, mag_w});
        val_w  = quad_w[1] ? -mag_s : mag_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sample_o <= '0;
        else if (step_i) sample_o <= val_w;
        else             sample_o <= '0;
    end

    // R7: paused edge drives zero
    a_r7_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> sample_o == '0);

    // R8: the most negative code never appears
    a_r8_no_min: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != {1'b1, {(OUT_W-1){1'b0}}});

    // R6: upper half-turn yields non-positive samples
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && phase_top_i[LUT_AW+1]) |=> sample_o <= 0);

endmodule

// File: rtl/fsk_ctrl.sv
module fsk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic req_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic step_o,
    output logic cur_bit_o
);

    import fskmod_pkg::*;

    run_state_t state_q;
    run_state_t state_n;
    logic       take_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAUSE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_PAUSE: if (enable_i)  state_n = ST_RUN;
            ST_RUN:   if (!enable_i) state_n = ST_PAUSE;
            default:  state_n = ST_PAUSE;
        endcase
    end

    always_comb begin
        step_o = enable_i;
        take_w = 1'b0;
        unique case (state_q)
            ST_PAUSE: take_w = 1'b0;
            ST_RUN:   take_w = enable_i & req_i & bit_valid_i;
            default:  take_w = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_bit_o <= 1'b0;
        else if (take_w) cur_bit_o <= bit_i;
    end

    // R3: bit is held unless a request meets a valid bit
    a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_i && req_i && bit_valid_i) |=> $stable(cur_bit_o));

    // R3: an accepted bit is the one offered
    a_r3_bit_take: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && req_i && bit_valid_i) |=> cur_bit_o == $past(bit_i));

endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator #(
    parameter int PHASE_W = 32,
    parameter int ACC_W   = 32,
    parameter int LUT_AW  = 6,
    parameter int OUT_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [PHASE_W-1:0]      carrier_word,
    input  logic [PHASE_W-1:0]      deviation_word,
    input  logic [ACC_W-1:0]        rate_word,
    input  logic                    data_bit,
    input  logic                    data_valid,
    output logic                    bit_req,
    output logic signed [OUT_W-1:0] sample
);

    localparam int TOP_W = LUT_AW + 2;

    logic               step_w;
    logic               cur_bit_w;
    logic [PHASE_W-1:0] phase_w;

    fsk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .req_i       (bit_req),
        .bit_valid_i (data_valid),
        .bit_i       (data_bit),
        .step_o      (step_w),
        .cur_bit_o   (cur_bit_w)
    );

    fsk_rate_gen #(.ACC_W(ACC_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_w),
        .rate_i (rate_word),
        .req_o  (bit_req)
    );

    fsk_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_w),
        .mark_i    (cur_bit_w),
        .carrier_i (carrier_word),
        .dev_i     (deviation_word),
        .phase_o   (phase_w)
    );

    fsk_sine_out #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_sine (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_w),
        .phase_top_i (phase_w[PHASE_W-1 -: TOP_W]),
        .sample_o    (sample)
    );

    // R1: reset output state seen on the first edge after release
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (bit_req == 1'b0 || rst_n));

endmodule

// File: tb/fsk_modulator_tb.sv
module fsk_modulator_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable = 1'b0;
    logic [31:0]        carrier_word = '0;
    logic [31:0]        deviation_word = '0;
    logic [31:0]        rate_word = '0;
    logic               data_bit = 1'b0;
    logic               data_valid = 1'b0;
    logic               bit_req;
    logic signed [11:0] sample;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_frac, m_phase;
    bit          m_req, m_bit;
    int          m_sample;
    logic [15:0] lfsr = 16'hACE1;
    int          sweep [256];

    always #4 clk = ~clk;

    fsk_modulator u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .carrier_word(carrier_word), .deviation_word(deviation_word),
        .rate_word(rate_word), .data_bit(data_bit), .data_valid(data_valid),
        .bit_req(bit_req), .sample(sample)
    );

    function automatic int exp_wave(input logic [31:0] ph);
        int quad, i, x, num, den, mag;
        quad = int'(ph[31:30]);
        i    = int'(ph[29:24]);
        if (quad == 1 || quad == 3) i = 63 - i;
        x   = 2 * i + 1;
        num = 2047 * 4 * x * (256 - x);
        den = 81920 - x * (256 - x);
        mag = num / den;
        return (quad >= 2) ? -mag : mag;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic [32:0] s;
        logic [31:0] inc;
        bit          nreq, nbit;
        logic [31:0] nfrac, nphase;
        int          nsample;
        nreq = 1'b0; nbit = m_bit; nfrac = m_frac; nphase = m_phase; nsample = 0;
        if (enable) begin
            s       = {1'b0, m_frac} + {1'b0, rate_word};
            nfrac   = s[31:0];
            nreq    = s[32];
            if (m_req && data_valid) nbit = data_bit;
            inc     = m_bit ? carrier_word + deviation_word : carrier_word - deviation_word;
            nphase  = m_phase + inc;
            nsample = exp_wave(m_phase);
        end
        m_req = nreq; m_bit = nbit; m_frac = nfrac; m_phase = nphase; m_sample = nsample;
        @(posedge clk);
        @(negedge clk);
        check("R2", "bit_req", int'(bit_req), int'(m_req));
        check(tag, "sample", int'(sample), m_sample);
    endtask

    task automatic next_bits(input bit use_valid);
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        data_bit   = lfsr[0];
        data_valid = use_valid ? 1'b1 : 1'b0;
    endtask

    task automatic run_bits(input int n, input logic [31:0] rate, input string tag);
        rate_word = rate;
        for (int k = 0; k < n; k++) begin
            next_bits(1'b1);
            tick(tag);
        end
    endtask

    initial begin
        m_frac = '0; m_phase = '0; m_req = 1'b0; m_bit = 1'b0; m_sample = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "sample in reset", int'(sample), 0);
        check("R1", "bit_req in reset", int'(bit_req), 0);
        rst_n = 1'b1;

        // R6: sweep every table position, one step of the top 8 phase bits per sample
        enable = 1'b1; carrier_word = 32'h0100_0000; deviation_word = '0; rate_word = '0;
        for (int n = 1; n <= 256; n++) begin
            tick("R6");
            sweep[n-1] = int'(sample);
        end
        // R8: half-turn antisymmetry and quadrant mirror
        for (int k = 0; k < 128; k++) check("R8", "negated half", sweep[k+128], -sweep[k]);
        for (int k = 0; k < 64; k++)  check("R8", "mirrored quadrant", sweep[64+k], sweep[63-k]);

        // R4, R5: mark/space switching at several bit rates
        carrier_word   = 32'h1555_5555;
        deviation_word = 32'h0051_EB85;
        run_bits(300, 32'h2000_0000, "R4");
        run_bits(400, 32'h0A81_4D2F, "R5");
        run_bits(200, 32'hFFFF_FFFF, "R4");
        deviation_word = 32'h3000_0000;
        carrier_word   = 32'h1000_0000;
        run_bits(200, 32'h4000_0001, "R4");

        // R3: no valid bit offered, previous bit must repeat
        rate_word = 32'h3000_0000;
        for (int k = 0; k < 200; k++) begin
            next_bits(k % 7 == 0);
            tick("R3");
        end

        // R7: enable toggling, state held through pauses
        for (int k = 0; k < 400; k++) begin
            enable = ((k / 3) % 4) != 0 || (k % 5 == 0);
            next_bits(1'b1);
            tick(enable ? "R5" : "R7");
        end
        enable = 1'b1;
        run_bits(100, 32'h0A81_4D2F, "R7");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule